// File: doc/BRIEF.md
# I2C Master Byte Receiver with Acknowledge-Phase Wait

This block receives bytes as an I2C master after the bus has been claimed and the slave has been addressed. A host pulses a start input while the block is idle. The block then generates SCL and samples SDA for eight data bits, and it issues a ninth clock for the acknowledge. It repeats this for each byte until the host requests a stop condition. Both lines are open-drain: each output only pulls its wire low. The block samples the wire values back, so a slave can stretch SCL.

Each received byte is moved to a data register. That transfer raises an interrupt flag, a byte-complete flag and a register-full flag. The host can turn on an optional wait mode. In wait mode the block also raises the interrupt flag when the eighth data clock falls. It then keeps SCL low until the host clears the flag, so the host can decide on the acknowledge and on stopping before the ninth clock goes out. The SCL low and high times both come from a divider count of the system clock.

Top module: `i2c_mrx_wait`

## Requirements
- R1: After reset the block is idle. busy, scl_oe, sda_oe, irq, rx_done, full and overrun are all 0.
- R2: A start_rx pulse while idle sets busy and pulls SCL low on the next cycle. Bytes of nine clocks each then follow back to back until a stop is requested. start_rx while busy is ignored.
- R3: The SCL low phase and the SCL high phase each last max(2, div_cnt) system clocks. High time is counted only in cycles where scl_in reads 1, so a slave holding SCL low lengthens the period without shortening the high phase.
- R4: SDA is sampled in the last cycle of each data clock's high phase. With lsb_first = 0 the first bit is rx_data[7]; with lsb_first = 1 the first bit is rx_data[0].
- R5: During the ninth clock the block pulls SDA low (ACK) when ack_ctl was 0, and releases it (NACK) when ack_ctl was 1. ack_ctl is captured when the ninth clock's low phase begins.
- R6: In the first cycle that scl_in reads 1 in the ninth clock, the block updates rx_data and sets irq, rx_done and full.
- R7: With wait_en = 1, irq rises with rx_done = 0 when the eighth data clock falls. SCL then stays low until irq is cleared, and only after that is the ninth clock issued.
- R8: clr_irq clears irq and rx_done. rd_data clears full. A set in the same cycle takes priority over a clear.
- R9: If a byte completes while full is still 1, overrun becomes 1. It stays at 1 until the next accepted start_rx.
- R10: A stop_req while busy takes effect after the ninth clock of the current byte. The sequence is: SDA pulled low with SCL low for one half-period, then SCL released and counted high for one half-period, then SDA released with SCL high. One half-period later busy falls.
- R11: The block changes sda_oe only while it pulls SCL low. The one exception is the SDA release that forms the stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_cnt | input | DIVW | Half-period length in system clocks (values below 2 act as 2) |
| wait_en | input | 1 | Pause before the acknowledge clock |
| ack_ctl | input | 1 | 0: send ACK, 1: send NACK |
| lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| start_rx | input | 1 | Pulse: begin reception |
| stop_req | input | 1 | Pulse: stop after the current byte |
| clr_irq | input | 1 | Pulse: clear irq and rx_done |
| rd_data | input | 1 | Pulse: data register read, clears full |
| scl_in | input | 1 | Sampled SCL wire |
| sda_in | input | 1 | Sampled SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | 8 | Last received byte |
| irq | output | 1 | Interrupt flag |
| rx_done | output | 1 | Byte fully received |
| full | output | 1 | Data register holds an unread byte |
| overrun | output | 1 | A byte completed while full was set |
| busy | output | 1 | Block owns the bus |

## Verification
The properties assume that div_cnt and lsb_first change only while busy is 0. They also assume that scl_in can read 1 only while scl_oe is 0, and that the host pulses clr_irq and rd_data for single cycles. The bench changes divider and bit order only between transfers. It models SCL as the AND of the block's release and a slave hold, and the slave hold is a random delay applied only after the block has released the line. Stop is always preceded by a NACKed last byte, so the slave model has released SDA when the stop begins.

// File: rtl/irx_pkg.sv
// Shared definitions for the I2C master receiver.
// Assumes: nothing beyond the SystemVerilog enum rules.
package irx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_PAUSE,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C
    } irx_state_e;
endpackage

// File: rtl/irx_halfper.sv
// Half-period timer: counts the cycles in which run is set and flags the last one.
// Assumes: div_cnt is stable while a phase is counting; DIVW >= 2.
module irx_halfper #(
    parameter int unsigned DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div_cnt,
    output logic            expire,
    output logic            first
);
    localparam logic [DIVW-1:0] MIN_DIV = DIVW'(2);

    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] lim;

    // Clamp the requested length to the minimum.
    always_comb lim = (div_cnt < MIN_DIV) ? MIN_DIV : div_cnt;

    assign expire = run && (cnt == (lim - DIVW'(1)));
    assign first  = run && (cnt == '0);

    // Advance while running, restart after the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (expire) cnt <= '0;
        else if (run)    cnt <= cnt + DIVW'(1);
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < lim);
endmodule

// File: rtl/irx_shreg.sv
// Receive shift register. Each shift takes in one bit, in either bit order.
// Assumes: lsb_first is stable across one byte.
module irx_shreg #(
    parameter int unsigned NB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift,
    input  logic          bit_in,
    input  logic          lsb_first,
    output logic [NB-1:0] q
);
    // Shift a sampled bit in from the side chosen by the bit order.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (shift) begin
            if (lsb_first)  q <= {bit_in, q[NB-1:1]};
            else            q <= {q[NB-2:0], bit_in};
        end
    end
endmodule

// File: rtl/irx_ctrl.sv
// Bit sequencer: low/high phases per clock, the pause before the acknowledge clock,
// the acknowledge drive and the stop sequence.
// Assumes: the bus is already owned with SCL low when start arrives; irq is the host flag.
module irx_ctrl
    import irx_pkg::*;
#(
    parameter int unsigned NB = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop_req,
    input  logic wait_en,
    input  logic ack_ctl,
    input  logic irq,
    input  logic scl_in,
    input  logic tmr_expire,
    input  logic tmr_first,
    output logic tmr_run,
    output logic shift_en,
    output logic set_mid,
    output logic set_done,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy
);
    localparam int unsigned    BW        = $clog2(NB + 1);
    localparam logic [BW-1:0]  LAST_DATA = BW'(NB - 1);
    localparam logic [BW-1:0]  ACK_BIT   = BW'(NB);

    irx_state_e    st, st_nx;
    logic [BW-1:0] bit_q, bit_nx;
    logic          ack_q, ack_nx;
    logic          stop_pend;
    logic          go_stop;

    assign go_stop = stop_pend | stop_req;
    assign busy    = (st != ST_IDLE);

    // Line drives and timer/flag strobes that follow from the state.
    always_comb begin
        scl_oe   = (st == ST_LOW) || (st == ST_PAUSE) || (st == ST_STOP_A);
        sda_oe   = (((st == ST_LOW) || (st == ST_HIGH) || (st == ST_PAUSE))
                    && (bit_q == ACK_BIT) && !ack_q)
                   || (st == ST_STOP_A) || (st == ST_STOP_B);
        tmr_run  = (st == ST_LOW) || (st == ST_STOP_A) || (st == ST_STOP_C)
                   || (((st == ST_HIGH) || (st == ST_STOP_B)) && scl_in);
        shift_en = (st == ST_HIGH) && tmr_expire && (bit_q != ACK_BIT);
        set_done = (st == ST_HIGH) && tmr_first && (bit_q == ACK_BIT);
        set_mid  = (st == ST_HIGH) && tmr_expire && (bit_q == LAST_DATA) && wait_en;
    end

    // Next state, bit index and captured acknowledge value.
    always_comb begin
        st_nx  = st;
        bit_nx = bit_q;
        ack_nx = ack_q;
        unique case (st)
            ST_IDLE: if (start) begin
                st_nx  = ST_LOW;
                bit_nx = '0;
            end
            ST_LOW: if (tmr_expire) st_nx = ST_HIGH;
            ST_HIGH: if (tmr_expire) begin
                if (bit_q == LAST_DATA) begin
                    bit_nx = ACK_BIT;
                    ack_nx = ack_ctl;
                    st_nx  = wait_en ? ST_PAUSE : ST_LOW;
                end else if (bit_q == ACK_BIT) begin
                    bit_nx = '0;
                    st_nx  = go_stop ? ST_STOP_A : ST_LOW;
                end else begin
                    bit_nx = bit_q + BW'(1);
                    st_nx  = ST_LOW;
                end
            end
            ST_PAUSE: if (!irq) begin
                st_nx  = ST_LOW;
                ack_nx = ack_ctl;
            end
            ST_STOP_A: if (tmr_expire) st_nx = ST_STOP_B;
            ST_STOP_B: if (tmr_expire) st_nx = ST_STOP_C;
            ST_STOP_C: if (tmr_expire) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            bit_q <= '0;
            ack_q <= 1'b1;
        end else begin
            st    <= st_nx;
            bit_q <= bit_nx;
            ack_q <= ack_nx;
        end
    end

    // Remember a stop request until the byte boundary consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       stop_pend <= 1'b0;
        else if ((st == ST_HIGH) && (st_nx == ST_STOP_A)) stop_pend <= 1'b0;
        else if (stop_req && busy)                        stop_pend <= 1'b1;
    end

    // R11
    sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (scl_oe || (st == ST_STOP_C)));

    // R7
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PAUSE) && irq) |=> scl_oe);
endmodule

// File: rtl/i2c_mrx_wait.sv
// I2C master byte receiver with an optional pause before the acknowledge clock.
// Holds the host-visible flags and data register; sequencing lives in irx_ctrl.
// Assumes: div_cnt and lsb_first change only while busy is 0; host strobes are one cycle.
module i2c_mrx_wait #(
    parameter int unsigned DIVW = 8,
    parameter int unsigned NB   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] div_cnt,
    input  logic            wait_en,
    input  logic            ack_ctl,
    input  logic            lsb_first,
    input  logic            start_rx,
    input  logic            stop_req,
    input  logic            clr_irq,
    input  logic            rd_data,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            scl_oe,
    output logic            sda_oe,
    output logic [NB-1:0]   rx_data,
    output logic            irq,
    output logic            rx_done,
    output logic            full,
    output logic            overrun,
    output logic            busy
);
    logic          tmr_run, tmr_expire, tmr_first;
    logic          shift_en, set_mid, set_done;
    logic [NB-1:0] shreg_q;

    irx_halfper #(.DIVW(DIVW)) tmr_i (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .div_cnt(div_cnt),
        .expire(tmr_expire), .first(tmr_first)
    );

    irx_shreg #(.NB(NB)) shr_i (
        .clk(clk), .rst_n(rst_n), .shift(shift_en), .bit_in(sda_in),
        .lsb_first(lsb_first), .q(shreg_q)
    );

    irx_ctrl #(.NB(NB)) ctl_i (
        .clk(clk), .rst_n(rst_n), .start(start_rx), .stop_req(stop_req),
        .wait_en(wait_en), .ack_ctl(ack_ctl), .irq(irq), .scl_in(scl_in),
        .tmr_expire(tmr_expire), .tmr_first(tmr_first), .tmr_run(tmr_run),
        .shift_en(shift_en), .set_mid(set_mid), .set_done(set_done),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy)
    );

    // Host flags and data register; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            rx_done <= 1'b0;
            full    <= 1'b0;
            overrun <= 1'b0;
            rx_data <= '0;
        end else begin
            if (set_mid || set_done) irq <= 1'b1;
            else if (clr_irq)        irq <= 1'b0;
            if (set_done)            rx_done <= 1'b1;
            else if (clr_irq)        rx_done <= 1'b0;
            if (set_done)            full <= 1'b1;
            else if (rd_data)        full <= 1'b0;
            if (set_done && full)         overrun <= 1'b1;
            else if (start_rx && !busy)   overrun <= 1'b0;
            if (set_done)            rx_data <= shreg_q;
        end
    end

    // R6
    done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> (full && irq));

    // R9
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(full));

    // R10
    release_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_mrx_wait_tb_top.sv
`timescale 1ns/1ps
module i2c_mrx_wait_tb_top;
    localparam int DIVW = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n, start_rx, stop_req, clr_irq, rd_data;
    logic            wait_en, ack_ctl, lsb_first;
    logic [DIVW-1:0] div_cnt;
    logic            scl_oe, sda_oe, irq, rx_done, full, overrun, busy;
    logic [7:0]      rx_data;
    logic            stretch_hold = 1'b0;
    logic            slave_drv = 1'b1;

    wire scl_line = ~scl_oe & ~stretch_hold;
    wire sda_line = ~sda_oe & slave_drv;

    i2c_mrx_wait #(.DIVW(DIVW), .NB(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .div_cnt(div_cnt), .wait_en(wait_en),
        .ack_ctl(ack_ctl), .lsb_first(lsb_first), .start_rx(start_rx),
        .stop_req(stop_req), .clr_irq(clr_irq), .rd_data(rd_data),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rx_data(rx_data), .irq(irq), .rx_done(rx_done), .full(full),
        .overrun(overrun), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;

    // slave model state
    logic [7:0] txb [0:7];
    int  k = -1;
    int  bidx = 0;
    bit  active = 1'b0;
    bit  stretch_en = 1'b0;
    int  stretch_cnt = 0;
    int  hi_len = 0;
    int  hi_err = 0;
    int  exp_hi = 2;
    int  ack_seen = 1;
    int  stop_seen = 0;
    int  illegal = 0;
    logic prev_scl = 1'b1;
    logic prev_sda = 1'b1;

    function automatic int eff_div(int d);
        return (d < 2) ? 2 : d;
    endfunction

    function automatic logic slave_bit(logic [7:0] b, int idx, logic lsb);
        return lsb ? b[idx] : b[7-idx];
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Slave and bus monitor, evaluated between clock edges.
    initial begin
        forever begin
            logic sc, sd;
            @(negedge clk);
            if (scl_oe) stretch_cnt = stretch_en ? int'($urandom_range(0, 3)) : 0;
            else if (stretch_cnt > 0) stretch_cnt--;
            stretch_hold = (stretch_cnt > 0);
            sc = !scl_oe && !stretch_hold;
            sd = !sda_oe && slave_drv;
            if (!prev_scl && sc) begin
                hi_len = 0;
                if (k == 8) begin
                    ack_seen = int'(sd);
                    if (sd) active = 1'b0;
                end
            end
            if (sc) hi_len++;
            if (prev_scl && sc && (prev_sda != sd)) begin
                if (sd) stop_seen++;
                else    illegal++;
            end
            if (prev_scl && !sc) begin
                if (k >= 0 && hi_len != exp_hi) hi_err++;
                hi_len = 0;
                k++;
                if (k == 9) begin
                    k = 0;
                    bidx++;
                end
            end
            slave_drv = (active && k >= 0 && k < 8) ? slave_bit(txb[bidx], k, lsb_first) : 1'b1;
            prev_scl = sc;
            prev_sda = !sda_oe && slave_drv;
        end
    end

    task automatic wait_irq();
        while (!irq) @(negedge clk);
    endtask

    task automatic run_frame(int nbytes, bit wmode, int div, bit lsb, bit str, int ovr_at);
        int st0, ill0;
        div_cnt    = DIVW'(div);
        lsb_first  = lsb;
        wait_en    = wmode;
        ack_ctl    = (nbytes == 1);
        stretch_en = str;
        exp_hi     = eff_div(div);
        for (int i = 0; i < nbytes; i++) txb[i] = 8'($urandom);
        k = -1; bidx = 0; active = 1'b1; hi_err = 0;
        st0 = stop_seen; ill0 = illegal;
        @(negedge clk) start_rx = 1'b1;
        @(negedge clk) start_rx = 1'b0;
        chk(busy && scl_oe, "R2 start", {busy, scl_oe}, 2'b11);
        chk(!overrun, "R9 cleared by start", overrun, 0);
        for (int b = 0; b < nbytes; b++) begin
            bit last;
            last = (b == nbytes - 1);
            if (wmode) begin
                int bad;
                wait_irq();
                chk(rx_done == 1'b0, "R7 mid-frame flag", rx_done, 0);
                bad = 0;
                for (int c = 0; c < 40; c++) begin
                    @(negedge clk);
                    if (scl_line || !irq) bad++;
                end
                chk(bad == 0, "R7 SCL held low", bad, 0);
                ack_ctl = last;
                if (last) begin
                    wait_en  = 1'b0;
                    stop_req = 1'b1;
                end
                clr_irq = 1'b1;
                @(negedge clk) begin clr_irq = 1'b0; stop_req = 1'b0; end
            end
            wait_irq();
            chk(rx_done && full, "R6 flags at ninth clock", {rx_done, full}, 2'b11);
            chk(rx_data == txb[b], "R4 received byte", rx_data, txb[b]);
            chk(ack_seen == int'(last), "R5 acknowledge level", ack_seen, last);
            if (ovr_at >= 0 && b == ovr_at + 1)
                chk(overrun == 1'b1, "R9 overrun", overrun, 1);
            if (!wmode) begin
                if (b + 1 == nbytes - 1) ack_ctl = 1'b1;
                if (last) stop_req = 1'b1;
            end
            clr_irq = 1'b1;
            rd_data = (b != ovr_at);
            @(negedge clk) begin clr_irq = 1'b0; rd_data = 1'b0; stop_req = 1'b0; end
            chk(!irq && !rx_done, "R8 irq cleared", {irq, rx_done}, 0);
            if (b != ovr_at) chk(!full, "R8 full cleared", full, 0);
            else             chk(full, "R8 full kept without read", full, 1);
        end
        while (busy) @(negedge clk);
        chk(stop_seen == st0 + 1, "R10 stop condition", stop_seen - st0, 1);
        chk(scl_line && sda_line && !scl_oe && !sda_oe, "R10 lines released",
            {scl_line, sda_line}, 2'b11);
        chk(hi_err == 0, "R3 high-phase length", hi_err, 0);
        chk(illegal == ill0, "R11 SDA edge while SCL high", illegal - ill0, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1c2a));
        rst_n = 1'b0; start_rx = 1'b0; stop_req = 1'b0; clr_irq = 1'b0; rd_data = 1'b0;
        wait_en = 1'b0; ack_ctl = 1'b0; lsb_first = 1'b0; div_cnt = DIVW'(4);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, scl_oe, sda_oe, irq, rx_done, full, overrun} == 7'b0, "R1 reset state",
            {busy, scl_oe, sda_oe, irq, rx_done, full, overrun}, 0);
        // directed corners
        run_frame(3, 1'b0, 4, 1'b0, 1'b0, -1);
        run_frame(2, 1'b1, 3, 1'b1, 1'b1, -1);
        run_frame(3, 1'b0, 1, 1'b0, 1'b1, 0);
        run_frame(1, 1'b0, 0, 1'b1, 1'b0, -1);
        run_frame(2, 1'b1, 2, 1'b0, 1'b1, 0);
        // random transfers
        for (int t = 0; t < 12; t++) begin
            int nb;
            nb = int'($urandom_range(1, 4));
            run_frame(nb, 1'($urandom), int'($urandom_range(0, 7)), 1'($urandom),
                      1'($urandom), (nb >= 2 && $urandom_range(0, 2) == 0) ? 0 : -1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule